// File: doc/BRIEF.md
# Correctable Error Status Register

This block holds the sticky flags for correctable link and controller faults. Detection logic elsewhere signals each fault with a one-cycle event pin. Each event sets its own flag in a 32-bit status word. Software reads that word and clears flags by writing ones to them. A second word, the mask, selects which events also raise a one-cycle correctable-error interrupt pulse. The mask never affects whether a flag gets recorded.

One uncorrectable class, the advisory non-fatal case, is handled specially. It is recorded in the correctable word and signalled on the correctable interrupt only. The separate non-fatal output responds only to its own non-advisory event pin.

The register port is a plain single-cycle access port with no back-pressure. A write strobe with an offset and data takes effect on the next rising clock edge. Read data is a combinational function of the offset and reflects the registers as they stand in the current cycle. The fault event pins and both interrupt outputs are plain control and status pins with no handshake.

Top module: `cerr_status_top`

## Requirements
- R1: After reset both the status word (offset 0x0) and the mask word (offset 0x4) read as zero, and both interrupt outputs are low.
- R2: Each event pin sets its own flag, which is readable from the cycle after the event. The positions are: receiver error at bit 0, bad TLP at bit 6, bad DLLP at bit 7, replay counter wrap at bit 8, replay timer expiry at bit 12, advisory non-fatal at bit 13, corrected internal error at bit 14 and header-log overflow at bit 15.
- R3: Bit 14 is set by the internal corrected-ECC event pin or by the client correctable-error input, separately or together.
- R4: A write to offset 0x0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0. The effect is visible in the next cycle.
- R5: In both words, bits 1-5, 9-11 and 16-31 always read zero and ignore writes.
- R6: The state of the mask has no effect on whether an event sets its flag.
- R7: The correctable interrupt is high for exactly the cycle after a cycle in which any event arrives whose mask bit is 0. This holds even when the flag was already set. A masked event alone raises no pulse. A mask bit is 1 to mask. Bit 14 is masked for both of its sources. A mask write takes effect for events from the next cycle on.
- R8: An advisory non-fatal event raises the correctable interrupt when unmasked and never raises the non-fatal output.
- R9: The non-fatal output is high for exactly the cycle after the non-fatal event pin is high, and at no other time.
- R10: When an event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R11: A write to offset 0x4 loads the mask word, keeping only the bits listed in R2. Offsets other than 0x0 and 0x4 read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_err | input | 1 | Receive-side physical layer fault |
| ev_bad_tlp | input | 1 | Received TLP rejected by the link layer |
| ev_bad_dllp | input | 1 | CRC fault in a received DLLP |
| ev_replay_wrap | input | 1 | Replay counter wrapped after repeated retransmission |
| ev_replay_tmo | input | 1 | Replay timer expired |
| ev_advisory_nf | input | 1 | Advisory non-fatal case of an uncorrectable fault |
| ev_int_ecc | input | 1 | Corrected ECC fault in an internal RAM |
| client_corr_in | input | 1 | Client-signalled correctable fault |
| ev_hdr_ovf | input | 1 | Header log could not take a new entry |
| ev_nonfatal | input | 1 | Non-advisory non-fatal fault |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| corr_irq | output | 1 | Correctable-error pulse |
| nonfatal_irq | output | 1 | Non-fatal-error pulse |

## Verification
Some rules are checked by assertions on every cycle. These are the per-cycle relations between event pins and flags: setting, setting despite the mask, bit 14 from either source, the set-over-clear priority, and the clear itself. The assertions also check that reserved bits are zero, that each interrupt pulse has a matching cause in the previous cycle, and that an advisory event never reaches the non-fatal output. Some behaviour only the bench scenarios can show. That covers the exact word values after sequences of writes and events, the mask load and its reserved bits, unmapped offsets, and repeated events on a flag that is already set. It also covers the timing of a mask change relative to a same-cycle event, which the bench compares against its own arithmetic model across swept and random stimulus.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

  // Number of event sources that feed flags (bit 14 has two sources).
  localparam int CERR_SRC_N = 9;

  // Flag positions; software decodes these, so they are fixed.
  localparam int CERR_POS_RX    = 0;
  localparam int CERR_POS_TLP   = 6;
  localparam int CERR_POS_DLLP  = 7;
  localparam int CERR_POS_WRAP  = 8;
  localparam int CERR_POS_TMO   = 12;
  localparam int CERR_POS_ADV   = 13;
  localparam int CERR_POS_INT   = 14;
  localparam int CERR_POS_HOVF  = 15;

  // Implemented bits of both words.
  localparam logic [31:0] CERR_IMPL = 32'h0000_F1C1;

  // Source index to flag position.
  function automatic int cerr_src_pos(input int src);
    case (src)
      0:       return CERR_POS_RX;
      1:       return CERR_POS_TLP;
      2:       return CERR_POS_DLLP;
      3:       return CERR_POS_WRAP;
      4:       return CERR_POS_TMO;
      5:       return CERR_POS_ADV;
      6:       return CERR_POS_INT;   // internal ECC
      7:       return CERR_POS_INT;   // client input
      default: return CERR_POS_HOVF;
    endcase
  endfunction

  typedef struct packed {
    logic wr_status;
    logic wr_mask;
  } cerr_wr_t;

endpackage

// File: rtl/cerr_regport.sv
module cerr_regport #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    status_i,
  input  logic [DATA_W-1:0]    mask_i,
  output cerr_pkg::cerr_wr_t   wr_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_OFS);

  logic hit_status, hit_mask;

  assign hit_status = (reg_addr == A_STATUS);
  assign hit_mask   = (reg_addr == A_MASK);

  always_comb begin
    wr_o.wr_status = reg_wr_en && hit_status;
    wr_o.wr_mask   = reg_wr_en && hit_mask;
  end

  always_comb begin
    if (hit_status)    rdata_o = status_i;
    else if (hit_mask) rdata_o = mask_i;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/cerr_flag_bank.sv
module cerr_flag_bank #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] flags_o
);
  logic [DATA_W-1:0] clr;
  logic [DATA_W-1:0] flags_d;

  assign clr = wr_i ? wdata_i : '0;
  // Clear first, then set, so a same-cycle event wins.
  assign flags_d = ((flags_o & ~clr) | set_i) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flags_d;
  end
endmodule

// File: rtl/cerr_mask_reg.sv
module cerr_mask_reg #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & IMPL;
  end
endmodule

// File: rtl/cerr_irq_gen.sv
module cerr_irq_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              nonfatal_ev_i,
  output logic              corr_o,
  output logic              nonfatal_o
);
  logic corr_d;

  assign corr_d = |(set_i & ~mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_o     <= 1'b0;
      nonfatal_o <= 1'b0;
    end else begin
      corr_o     <= corr_d;
      nonfatal_o <= nonfatal_ev_i;
    end
  end
endmodule

// File: rtl/cerr_status_top.sv
module cerr_status_top #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_err,
  input  logic              ev_bad_tlp,
  input  logic              ev_bad_dllp,
  input  logic              ev_replay_wrap,
  input  logic              ev_replay_tmo,
  input  logic              ev_advisory_nf,
  input  logic              ev_int_ecc,
  input  logic              client_corr_in,
  input  logic              ev_hdr_ovf,
  input  logic              ev_nonfatal,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              corr_irq,
  output logic              nonfatal_irq
);
  import cerr_pkg::*;

  localparam logic [DATA_W-1:0] IMPL = DATA_W'(CERR_IMPL);

  logic [CERR_SRC_N-1:0] ev_vec;
  logic [DATA_W-1:0]     src_vec [CERR_SRC_N];
  logic [DATA_W-1:0]     set_vec;
  logic [DATA_W-1:0]     status_q;
  logic [DATA_W-1:0]     mask_q;
  cerr_wr_t              wr;
  logic                  wr_status;

  assign ev_vec = {ev_hdr_ovf, client_corr_in, ev_int_ecc, ev_advisory_nf,
                   ev_replay_tmo, ev_replay_wrap, ev_bad_dllp, ev_bad_tlp,
                   ev_rx_err};

  // One positioned vector per source, then merged.
  for (genvar s = 0; s < CERR_SRC_N; s++) begin : g_src
    assign src_vec[s] = ev_vec[s] ? (DATA_W'(1) << cerr_src_pos(s)) : '0;
  end

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < CERR_SRC_N; s++) set_vec = set_vec | src_vec[s];
  end

  assign wr_status = wr.wr_status;

  cerr_regport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_port (
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .status_i(status_q), .mask_i(mask_q),
    .wr_o(wr), .rdata_o(reg_rdata)
  );

  cerr_flag_bank #(.DATA_W(DATA_W), .IMPL(IMPL)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec),
    .wr_i(wr.wr_status), .wdata_i(reg_wdata), .flags_o(status_q)
  );

  cerr_mask_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(wr.wr_mask),
    .wdata_i(reg_wdata), .mask_o(mask_q)
  );

  cerr_irq_gen #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .mask_i(mask_q),
    .nonfatal_ev_i(ev_nonfatal), .corr_o(corr_irq), .nonfatal_o(nonfatal_irq)
  );
endmodule

// File: rtl/cerr_status_chk.sv
module cerr_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rx_err,
  input logic              ev_bad_tlp,
  input logic              ev_bad_dllp,
  input logic              ev_replay_wrap,
  input logic              ev_replay_tmo,
  input logic              ev_advisory_nf,
  input logic              ev_int_ecc,
  input logic              client_corr_in,
  input logic              ev_hdr_ovf,
  input logic              ev_nonfatal,
  input logic              wr_status,
  input logic              wd0,
  input logic              wd6,
  input logic              st0,
  input logic              st6,
  input logic              st14,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              corr_irq,
  input logic              nonfatal_irq
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(cerr_pkg::CERR_IMPL);

  logic [DATA_W-1:0] cause;
  always_comb begin
    cause = '0;
    cause[0]  = ev_rx_err;
    cause[6]  = ev_bad_tlp;
    cause[7]  = ev_bad_dllp;
    cause[8]  = ev_replay_wrap;
    cause[12] = ev_replay_tmo;
    cause[13] = ev_advisory_nf;
    cause[14] = ev_int_ecc | client_corr_in;
    cause[15] = ev_hdr_ovf;
  end

  p_rx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_err |=> st0);
  p_ecc_or_client_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_int_ecc || client_corr_in) |=> st14);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wd0 && !ev_rx_err) |=> !st0);
  p_mask_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_err && mask_q[0]) |=> st0);
  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_irq |-> $past(|(cause & ~mask_q)));
  p_irq_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause & ~mask_q)) |=> corr_irq);
  p_advisory_steer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_advisory_nf && !ev_nonfatal) |=> !nonfatal_irq);
  p_nonfatal_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nonfatal_irq |-> $past(ev_nonfatal));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wd6 && ev_bad_tlp) |=> st6);

  always_comb begin
    if (rst_n) begin
      a_rsvd_zero_r5: assert ((reg_rdata & ~IMPL) == '0);
    end
  end
endmodule

bind cerr_status_top cerr_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_rx_err(ev_rx_err), .ev_bad_tlp(ev_bad_tlp), .ev_bad_dllp(ev_bad_dllp),
  .ev_replay_wrap(ev_replay_wrap), .ev_replay_tmo(ev_replay_tmo),
  .ev_advisory_nf(ev_advisory_nf), .ev_int_ecc(ev_int_ecc),
  .client_corr_in(client_corr_in), .ev_hdr_ovf(ev_hdr_ovf),
  .ev_nonfatal(ev_nonfatal), .wr_status(wr_status),
  .wd0(reg_wdata[0]), .wd6(reg_wdata[6]),
  .st0(status_q[0]), .st6(status_q[6]), .st14(status_q[14]),
  .mask_q(mask_q), .reg_rdata(reg_rdata),
  .corr_irq(corr_irq), .nonfatal_irq(nonfatal_irq)
);

// File: tb/cerr_status_top_tb.sv
module cerr_status_top_tb;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [31:0] IMPL = 32'h0000_F1C1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;   // 0 rx,1 tlp,2 dllp,3 wrap,4 tmo,5 adv,6 ecc,7 client,8 hovf,9 nonfatal
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          corr_irq, nonfatal_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_status = '0;
  logic [31:0] m_mask = '0;

  always #10 clk = ~clk;

  cerr_status_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_err(ev[0]), .ev_bad_tlp(ev[1]), .ev_bad_dllp(ev[2]),
    .ev_replay_wrap(ev[3]), .ev_replay_tmo(ev[4]), .ev_advisory_nf(ev[5]),
    .ev_int_ecc(ev[6]), .client_corr_in(ev[7]), .ev_hdr_ovf(ev[8]),
    .ev_nonfatal(ev[9]),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .corr_irq(corr_irq), .nonfatal_irq(nonfatal_irq)
  );

  function automatic logic [31:0] ev_bits(input logic [9:0] e);
    logic [31:0] v = '0;
    if (e[0]) v[0] = 1'b1;
    if (e[1]) v[6] = 1'b1;
    if (e[2]) v[7] = 1'b1;
    if (e[3]) v[8] = 1'b1;
    if (e[4]) v[12] = 1'b1;
    if (e[5]) v[13] = 1'b1;
    if (e[6] || e[7]) v[14] = 1'b1;
    if (e[8]) v[15] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Apply one cycle of stimulus at a negedge, check at the following negedge.
  task automatic step(input logic [9:0] e, input logic wr,
                      input logic [3:0] a, input logic [31:0] wd,
                      input string req);
    logic [31:0] setv, clr, d;
    logic exp_c, exp_nf;
    ev = e; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    setv   = ev_bits(e);
    exp_c  = |(setv & ~m_mask);
    exp_nf = e[9];
    clr    = (wr && a == 4'h0) ? wd : 32'h0;
    m_status = ((m_status & ~clr) | setv) & IMPL;
    if (wr && a == 4'h4) m_mask = wd & IMPL;
    @(negedge clk);
    chk(req, "corr_irq", {31'h0, corr_irq}, {31'h0, exp_c});
    chk(req, "nonfatal_irq", {31'h0, nonfatal_irq}, {31'h0, exp_nf});
    ev = '0; reg_wr_en = 1'b0;
    rd(4'h0, d); chk(req, "status", d, m_status);
    rd(4'h4, d); chk(req, "mask", d, m_mask);
    rd(4'h8, d); chk(req, "unmapped", d, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(4'h0, d); chk("R1", "status at reset", d, 32'h0);
    rd(4'h4, d); chk("R1", "mask at reset", d, 32'h0);
    chk("R1", "corr at reset", {31'h0, corr_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "nonfatal after reset", {31'h0, nonfatal_irq}, 32'h0);

    // R2 R3 R6 R7 R8 R9: each source alone, unmasked and fully masked
    for (int m = 0; m < 2; m++) begin
      step('0, 1'b1, 4'h4, m ? 32'hFFFF_FFFF : 32'h0, "R11");
      for (int i = 0; i < 10; i++) begin
        step(10'(1) << i, 1'b0, 4'h0, 32'h0, m ? "R6" : "R2");
        step(10'(1) << i, 1'b0, 4'h0, 32'h0, "R7");
        step('0, 1'b1, 4'h0, 32'hFFFF_FFFF, "R4");
      end
    end

    // R3: both bit-14 sources together, unmasked
    step('0, 1'b1, 4'h4, 32'h0, "R11");
    step(10'b00_1100_0000, 1'b0, 4'h0, 32'h0, "R3");
    // R8: advisory plus nothing else never reaches non-fatal
    step(10'b00_0010_0000, 1'b0, 4'h0, 32'h0, "R8");
    // R4: write of zero leaves flags
    step('0, 1'b1, 4'h0, 32'h0, "R4");
    // R10: set beats clear on the same bit
    step(10'b00_0000_0010, 1'b1, 4'h0, 32'hFFFF_FFFF, "R10");
    // R5: reserved bits written with ones in both words
    step('0, 1'b1, 4'h0, ~IMPL, "R5");
    step('0, 1'b1, 4'h4, ~IMPL, "R5");
    // R11: writes to unmapped offsets change nothing
    step('0, 1'b1, 4'h8, 32'hFFFF_FFFF, "R11");
    step('0, 1'b1, 4'hC, 32'hFFFF_FFFF, "R11");

    // R7: per-flag mask sweep, all sources firing
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b]) begin
        step('0, 1'b1, 4'h4, IMPL & ~(32'h1 << b), "R11");
        step(10'h1FF, 1'b0, 4'h0, 32'h0, "R7");
        step('0, 1'b1, 4'h4, 32'h1 << b, "R11");
        step(10'h1FF, 1'b0, 4'h0, 32'h0, "R6");
        step('0, 1'b1, 4'h0, 32'hFFFF_FFFF, "R4");
      end
    end

    // Mixed stimulus: sparse events with writes to any offset
    for (int k = 0; k < 400; k++) begin
      logic [9:0] e;
      logic w;
      logic [3:0] a;
      e = 10'($urandom) & 10'($urandom) & 10'($urandom);
      w = ($urandom % 3) == 0;
      a = 4'(($urandom % 4) * 4);
      step(e, w, a, $urandom, "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule